// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Selector

When an interrupt is sent in lowest-priority delivery mode, one of several processor units must be chosen to receive it. This block takes, for each candidate unit, a flag that says whether the unit's destination matched the interrupt and the unit's current 8-bit arbitration priority. It returns the index of the single unit that should take the interrupt, or reports that no unit matched.

Only the class nibble, the upper four bits of each priority, is compared. The subclass nibble has no effect. A lower class is preferred. When classes are equal, the candidate with the lower index wins. The selection is started by a one-cycle `start` pulse and ends with a one-cycle `done` pulse.

A parameter chooses how the selection is built:
- **Sequential scanner.** It visits one candidate per cycle, in index order, and keeps a running best.
- **Balanced comparison tree.** It gives the answer in the cycle after `start`.

Top module: `lowpri_dest_select`

## Requirements
- R1: Bits [3:0] of a candidate's priority (the subclass) never change the selection; only bits [7:4] (the class) are compared.
- R2: Among matching candidates, the one with the numerically lowest class is selected.
- R3: When two or more matching candidates share the lowest class, the one with the lowest index is selected.
- R4: A candidate whose match flag is 0 is never selected, whatever its priority.
- R5: When no match flag is set, `done` is followed by `tgt_valid` = 0 and `tgt_idx` = 0. Whenever `tgt_valid` is 0, `tgt_idx` is 0.
- R6: In sequential mode, `done` is high for exactly one cycle. It is raised by the clock edge that comes NUM_UNITS edges after the edge that sampled `start`. In tree mode, `done` is raised by the edge that sampled `start`.
- R7: `tgt_valid` and `tgt_idx` change only in a cycle where `done` is high. They hold their value until the next result.
- R8: In sequential mode, a `start` that arrives while `busy` is high is ignored: the scan in progress is not restarted and its `done` timing is unchanged.
- R9: After reset, `busy`, `done`, `tgt_valid` and `tgt_idx` are all 0.
- R10: In sequential mode, `busy` is high for the NUM_UNITS cycles between the accepted `start` and `done`, and is low while `done` is high. In tree mode, `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a selection |
| cand_match | input | NUM_UNITS | Bit k is set when unit k's destination matched |
| cand_prio | input | NUM_UNITS*8 | Arbitration priority of unit k, in bits [8k+7:8k] |
| busy | output | 1 | Sequential scan in progress |
| done | output | 1 | One-cycle pulse: a new result is on the outputs |
| tgt_valid | output | 1 | The result names a target |
| tgt_idx | output | SEL_W | Index of the chosen unit, 0 when there is none |

## Verification
The result checks assume that `cand_match` and `cand_prio` keep the values they had when `start` was sampled until `done` is raised. The reason is that the scanner reads the inputs over several cycles and the assertions judge the winner against the live inputs. The bench only changes these inputs in the same cycle as it raises `start`, and it holds them through the whole scan. This includes the case where a second `start` is sent in the middle of a scan. Priorities are drawn from a few classes with random subclasses, so that ties and subclass-only differences occur often.

// File: rtl/lpsel_pkg.sv
package lpsel_pkg;
  localparam int APR_W = 8;
  localparam int CLS_W = 4;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             vld;
    logic [CLS_W-1:0] cls;
    logic [IDX_W-1:0] idx;
  } entry_t;

  // class nibble of an arbitration priority; the subclass is dropped
  function automatic logic [CLS_W-1:0] apr_class(logic [APR_W-1:0] apr);
    return apr[APR_W-1 -: CLS_W];
  endfunction

  // challenger wins only when strictly lower class, so earlier entries keep ties
  function automatic entry_t keep_better(entry_t inc, entry_t chal);
    entry_t r;
    r = inc;
    if (chal.vld && (!inc.vld || (chal.cls < inc.cls))) r = chal;
    return r;
  endfunction

  function automatic entry_t make_entry(logic m, logic [APR_W-1:0] apr, logic [IDX_W-1:0] i);
    entry_t r;
    r.vld = m;
    r.cls = apr_class(apr);
    r.idx = m ? i : '0;
    return r;
  endfunction
endpackage

// File: rtl/lpsel_leaves.sv
module lpsel_leaves
  import lpsel_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       match,
  input  logic [N*APR_W-1:0] prio,
  output entry_t             ents [N]
);
  for (genvar k = 0; k < N; k++) begin : g_leaf
    assign ents[k] = make_entry(match[k], prio[k*APR_W +: APR_W], IDX_W'(k));
  end
endmodule

// File: rtl/lpsel_merge.sv
module lpsel_merge
  import lpsel_pkg::*;
(
  input  entry_t inc,
  input  entry_t chal,
  output entry_t win
);
  assign win = keep_better(inc, chal);
endmodule

// File: rtl/lpsel_tree.sv
module lpsel_tree
  import lpsel_pkg::*;
#(
  parameter int N = 8
) (
  input  entry_t ents [N],
  output entry_t best
);
  localparam int LVL = (N > 1) ? $clog2(N) : 1;
  localparam int P   = 1 << LVL;

  entry_t node [2*P-1];

  // leaves sit at P-1 .. 2P-2, padded with empty entries
  for (genvar k = 0; k < P; k++) begin : g_pad
    if (k < N) begin : g_real
      assign node[P-1+k] = ents[k];
    end else begin : g_empty
      assign node[P-1+k] = '0;
    end
  end

  // left child holds lower indices, so it is the incumbent
  for (genvar i = 0; i < P-1; i++) begin : g_node
    lpsel_merge u_m (
      .inc (node[2*i+1]),
      .chal(node[2*i+2]),
      .win (node[i])
    );
  end

  assign best = node[0];
endmodule

// File: rtl/lpsel_scan.sv
module lpsel_scan
  import lpsel_pkg::*;
#(
  parameter int N = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  entry_t ents [N],
  output logic   busy,
  output logic   step_evt,
  output logic   done,
  output entry_t result
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] pos_q;
  entry_t           acc_q, res_q, cur, merged;
  logic             last_step;

  always_comb begin
    cur = '0;
    for (int k = 0; k < N; k++)
      if (pos_q == IDX_W'(k)) cur = ents[k];
  end

  assign merged    = keep_better(acc_q, cur);
  assign step_evt  = busy_q;
  assign last_step = busy_q && (pos_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go) begin
          busy_q <= 1'b1;
          pos_q  <= '0;
          acc_q  <= '0;
        end
      end else if (last_step) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= merged;
      end else begin
        pos_q <= pos_q + 1'b1;
        acc_q <= merged;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/lowpri_dest_select.sv
module lowpri_dest_select
  import lpsel_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter bit SEQ_SCAN  = 1'b1,
  parameter int SEL_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_UNITS-1:0]       cand_match,
  input  logic [NUM_UNITS*APR_W-1:0] cand_prio,
  output logic                       busy,
  output logic                       done,
  output logic                       tgt_valid,
  output logic [SEL_W-1:0]           tgt_idx
);
  entry_t ents [NUM_UNITS];
  entry_t res;
  logic   scan_step;
  logic   result_load;

  lpsel_leaves #(.N(NUM_UNITS)) u_leaves (
    .match(cand_match),
    .prio (cand_prio),
    .ents (ents)
  );

  if (SEQ_SCAN) begin : g_seq
    lpsel_scan #(.N(NUM_UNITS)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (start),
      .ents    (ents),
      .busy    (busy),
      .step_evt(scan_step),
      .done    (result_load),
      .result  (res)
    );
  end else begin : g_tree
    entry_t best, res_q;
    logic   done_q;

    lpsel_tree #(.N(NUM_UNITS)) u_tree (
      .ents(ents),
      .best(best)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        res_q  <= '0;
      end else begin
        done_q <= start;
        if (start) res_q <= best;
      end
    end

    assign busy        = 1'b0;
    assign scan_step   = 1'b0;
    assign result_load = done_q;
    assign res         = res_q;
  end

  assign done      = result_load;
  assign tgt_valid = res.vld;
  assign tgt_idx   = res.vld ? res.idx[SEL_W-1:0] : '0;
endmodule

// File: rtl/lpsel_chk.sv
module lpsel_chk
  import lpsel_pkg::*;
#(
  parameter int N        = 8,
  parameter bit SEQ_SCAN = 1'b1,
  parameter int SEL_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [N-1:0]       cand_match,
  input logic [N*APR_W-1:0] cand_prio,
  input logic               busy,
  input logic               done,
  input logic               tgt_valid,
  input logic [SEL_W-1:0]   tgt_idx,
  input logic               scan_step
);
  logic [CLS_W-1:0] min_cls, sel_cls;
  logic [SEL_W-1:0] first_min;
  logic             sel_match;

  // minimum class over matching units, then the lowest index holding it
  always_comb begin
    min_cls = '1;
    for (int k = 0; k < N; k++)
      if (cand_match[k] && apr_class(cand_prio[k*APR_W +: APR_W]) < min_cls)
        min_cls = apr_class(cand_prio[k*APR_W +: APR_W]);
    first_min = '0;
    for (int k = N-1; k >= 0; k--)
      if (cand_match[k] && apr_class(cand_prio[k*APR_W +: APR_W]) == min_cls)
        first_min = SEL_W'(k);
    sel_cls   = '0;
    sel_match = 1'b0;
    for (int k = 0; k < N; k++)
      if (tgt_idx == SEL_W'(k)) begin
        sel_cls   = apr_class(cand_prio[k*APR_W +: APR_W]);
        sel_match = cand_match[k];
      end
  end

  assert_zero_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_valid |-> tgt_idx == '0);

  assert_valid_iff_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgt_valid == (|cand_match)));

  assert_sel_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tgt_valid) |-> sel_match);

  assert_lowest_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tgt_valid) |-> sel_cls == min_cls);

  assert_earliest_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tgt_valid) |-> tgt_idx == first_min);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid != $past(tgt_valid) || tgt_idx != $past(tgt_idx)) |-> done);

  if (SEQ_SCAN) begin : g_seq_props
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

    assert_step_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      scan_step |-> busy);

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
  end else begin : g_tree_props
    assert_tree_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !scan_step);

    assert_tree_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
  end
endmodule

bind lowpri_dest_select lpsel_chk #(
  .N(NUM_UNITS), .SEQ_SCAN(SEQ_SCAN), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cand_match(cand_match),
  .cand_prio(cand_prio), .busy(busy), .done(done), .tgt_valid(tgt_valid),
  .tgt_idx(tgt_idx), .scan_step(scan_step)
);

// File: tb/sim_lowpri_dest_select.sv
`timescale 1ns/1ps
module sim_lowpri_dest_select;
  localparam int N  = 5;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  match = '0;
  logic [N*8-1:0] prio = '0;

  logic          s_busy, s_done, s_valid, t_busy, t_done, t_valid;
  logic [SW-1:0] s_idx, t_idx;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R9";

  always #2.5 clk = ~clk;

  lowpri_dest_select #(.NUM_UNITS(N), .SEQ_SCAN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_match(match), .cand_prio(prio),
    .busy(s_busy), .done(s_done), .tgt_valid(s_valid), .tgt_idx(s_idx));

  lowpri_dest_select #(.NUM_UNITS(N), .SEQ_SCAN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_match(match), .cand_prio(prio),
    .busy(t_busy), .done(t_done), .tgt_valid(t_valid), .tgt_idx(t_idx));

  // behavioural expectation: lowest class, earliest index on ties
  task automatic ref_pick(output bit v, output int idx);
    int best_cls;
    v = 0; idx = 0; best_cls = 99;
    for (int k = 0; k < N; k++) begin
      int c;
      c = prio[k*8 +: 8] / 16;
      if (match[k] && c < best_cls) begin
        best_cls = c; idx = k; v = 1;
      end
    end
  endtask

  // cycle model, sequential variant
  int m0_cnt = 0; bit m0_done = 0, m0_valid = 0; int m0_idx = 0;
  bit m0_pv; int m0_pi;
  // cycle model, tree variant
  bit m1_done = 0, m1_valid = 0; int m1_idx = 0;

  always @(posedge clk) begin
    bit v; int i;
    if (!rst_n) begin
      m0_cnt = 0; m0_done = 0; m0_valid = 0; m0_idx = 0;
      m1_done = 0; m1_valid = 0; m1_idx = 0;
    end else begin
      m0_done = 0;
      if (m0_cnt > 0) begin
        m0_cnt--;
        if (m0_cnt == 0) begin
          m0_done = 1; m0_valid = m0_pv; m0_idx = m0_pi;
        end
      end else if (start) begin
        m0_cnt = N;
        ref_pick(m0_pv, m0_pi);
      end
      m1_done = start;
      if (start) begin
        ref_pick(v, i);
        m1_valid = v; m1_idx = i;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      check("R6", "seq done", int'(s_done), int'(m0_done));
      check("R10", "seq busy", int'(s_busy), int'(m0_cnt > 0));
      check(m0_done ? cur_tag : "R7", "seq valid", int'(s_valid), int'(m0_valid));
      check(m0_done ? cur_tag : "R7", "seq idx", int'(s_idx), m0_idx);
      check("R6", "tree done", int'(t_done), int'(m1_done));
      check("R10", "tree busy", int'(t_busy), 0);
      check(m1_done ? cur_tag : "R7", "tree valid", int'(t_valid), int'(m1_valid));
      check(m1_done ? cur_tag : "R7", "tree idx", int'(t_idx), m1_idx);
    end
  end

  task automatic run_case(string tag, logic [N-1:0] m, logic [N*8-1:0] p);
    @(negedge clk);
    cur_tag = tag;
    match = m; prio = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "busy", int'(s_busy), 0);
    check("R9", "done", int'(s_done), 0);
    check("R9", "valid", int'(s_valid), 0);
    check("R9", "idx", int'(s_idx), 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (2) @(negedge clk);

    // R2: distinct classes, minimum at index 3
    run_case("R2", 5'b11111, {8'h70, 8'h20, 8'h90, 8'h50, 8'h60});
    // R1: 0x3F and 0x30 share class 3; index 1 must win despite larger raw value
    run_case("R1", 5'b11111, {8'h80, 8'h80, 8'h30, 8'h3F, 8'h50});
    // R3: all candidates in one class
    run_case("R3", 5'b11111, {8'h41, 8'h42, 8'h4F, 8'h40, 8'h4E});
    // R4: lowest class belongs to an unmatched unit
    run_case("R4", 5'b10110, {8'h90, 8'h00, 8'hA0, 8'hB0, 8'h10});
    // R5: nothing matches
    run_case("R5", 5'b00000, {8'h10, 8'h20, 8'h30, 8'h40, 8'h50});
    // R4: only the last unit matches
    run_case("R4", 5'b10000, {8'hF0, 8'h00, 8'h00, 8'h00, 8'h00});

    // R8: extra start in mid-scan, inputs held
    @(negedge clk);
    cur_tag = "R8";
    match = 5'b01101; prio = {8'h30, 8'h22, 8'h60, 8'h25, 8'h40};
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (N + 3) @(negedge clk);

    // R3: random priorities with few classes so ties are frequent
    for (int t = 0; t < 40; t++) begin
      logic [N*8-1:0] p;
      for (int k = 0; k < N; k++)
        p[k*8 +: 8] = 8'(($urandom_range(0, 3) << 4) | $urandom_range(0, 15));
      run_case("R3", N'($urandom_range(0, (1 << N) - 1)), p);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule